// File: doc/BRIEF.md
# Synchronous Burst SRAM with Wrapping Counter

This block is a single-clock static memory for a second-level cache data array. Each word has two independent 9-bit lanes, each holding 8 data bits and 1 parity bit. An access starts when one of two active-low start strobes is sampled together with the external address. The processor strobe always starts a read. The controller strobe starts a read or a write, depending on the lane write enables.

After the start cycle, the two lowest address bits come from an internal 2-bit counter. An active-low advance input steps this counter on a continuation cycle, and holding advance high inserts a wait state. The counter runs in binary order and returns to its loaded value after four accesses. The upper address bits stay fixed for the whole burst.

Read data for an edge is presented during the following cycle. It reaches the bus only while the asynchronous output enable is low. The memory depth is set by the address width parameter.

Top module: `burst_sram`

## Requirements
- R1: A synchronous active-high reset leaves the device deselected with `q_drive` low and clears the burst counter.
- R2: The processor strobe (`proc_start_n` low) sampled with `enable_n` low starts a read at `addr`. The controller strobe, `wr_lane_n` and `wdata` have no effect on that edge, and memory is not changed.
- R3: With `proc_start_n` high, `ctrl_start_n` low and `enable_n` low, a burst starts at `addr`. It writes `wdata` on that edge if any `wr_lane_n` bit is 0, and it is a read otherwise.
- R4: Either strobe sampled low while `enable_n` is high deselects the device. No write happens, and `q_drive` is low afterwards.
- R5: `enable_n` is sampled only on an edge where a strobe is low. On continuation cycles it has no effect.
- R6: On a continuation cycle (both strobes high, device selected), `advance_n` low steps the counter before the access. `advance_n` high repeats the current address. Either way the cycle writes if any `wr_lane_n` bit is 0 and reads otherwise.
- R7: The low two address bits start at `addr[1:0]` and step by +1 modulo 4, so the fifth access of a burst returns to the start. `addr[ADDR_W-1:2]` is held for the whole burst.
- R8: After a processor-strobe start, a continuation cycle with `advance_n` high and a lane enabled writes `wdata` to the started address. This forms a two-cycle single write.
- R9: `wr_lane_n[0]` enables writing of `wdata[8:0]`, and `wr_lane_n[1]` enables writing of `wdata[17:9]`. A disabled lane keeps its stored value.
- R10: `q_drive` is high only while `out_en_n` is low, the device is selected and the last edge was a read. `out_en_n` acts without waiting for a clock edge. When `q_drive` is low, `q` reads zero.
- R11: While deselected, `advance_n` and `wr_lane_n` are ignored until a strobe is sampled with `enable_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | External word address |
| proc_start_n | input | 1 | Processor start strobe, active low, highest priority |
| ctrl_start_n | input | 1 | Controller start strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| enable_n | input | 1 | Chip enable, active low, sampled at a start |
| wr_lane_n | input | LANES | Per-lane write enables, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | LANES*LANE_W | Write data |
| q | output | LANES*LANE_W | Read data, zero when not driven |
| q_drive | output | 1 | High while read data owns the bus |

## Verification
The bench builds the block with an 8-bit address, which gives 256 words of two 9-bit lanes. This is small enough to fill every word through ordinary bursts before any read. Every later read cycle is then compared against a known value. The four word groups used for the wrap tests sit in different upper-address regions, so a counter that leaked a carry into the upper bits would read a neighbouring group and be reported.

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      proc_start_n,
  input  logic                      ctrl_start_n,
  input  logic                      advance_n,
  input  logic                      enable_n,
  input  logic [LANES-1:0]          wr_lane_n,
  input  logic                      out_en_n,
  input  logic [LANES*LANE_W-1:0]   wdata,
  output logic [LANES*LANE_W-1:0]   q,
  output logic                      q_drive
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int HI_W   = ADDR_W - 2;

  logic [DATA_W-1:0] mem [DEPTH];

  logic            sel_q, rd_q;
  logic [HI_W-1:0] hi_q;
  logic [1:0]      lo_q;

  logic            sel_d, rd_d, wr_d;
  logic [HI_W-1:0] hi_d;
  logic [1:0]      lo_d;

  logic start, any_wr;
  assign start  = !proc_start_n || !ctrl_start_n;
  assign any_wr = !(&wr_lane_n);

  always_comb begin
    sel_d = sel_q;
    hi_d  = hi_q;
    lo_d  = lo_q;
    wr_d  = 1'b0;
    rd_d  = 1'b0;
    if (start) begin
      if (enable_n) begin
        sel_d = 1'b0;
      end else begin
        sel_d = 1'b1;
        hi_d  = addr[ADDR_W-1:2];
        lo_d  = addr[1:0];
        wr_d  = proc_start_n && any_wr;
        rd_d  = !wr_d;
      end
    end else if (sel_q) begin
      if (!advance_n) lo_d = lo_q + 2'd1;
      wr_d = any_wr;
      rd_d = !any_wr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
      rd_q  <= 1'b0;
      hi_q  <= '0;
      lo_q  <= 2'd0;
    end else begin
      sel_q <= sel_d;
      rd_q  <= rd_d;
      hi_q  <= hi_d;
      lo_q  <= lo_d;
    end
  end

  logic [ADDR_W-1:0] wr_addr, rd_addr;
  assign wr_addr = {hi_d, lo_d};
  assign rd_addr = {hi_q, lo_q};

  always_ff @(posedge clk) begin
    if (!rst && wr_d) begin
      for (int g = 0; g < LANES; g++) begin
        if (!wr_lane_n[g]) mem[wr_addr][g*LANE_W +: LANE_W] <= wdata[g*LANE_W +: LANE_W];
      end
    end
  end

  assign q_drive = sel_q && rd_q && !out_en_n;
  assign q       = q_drive ? mem[rd_addr] : '0;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             proc_start_n,
  input logic             ctrl_start_n,
  input logic             advance_n,
  input logic             enable_n,
  input logic [LANES-1:0] wr_lane_n,
  input logic             out_en_n,
  input logic             q_drive,
  input logic             sel_q,
  input logic [1:0]       lo_q
);
  a_r10_drive_needs_oe: assert property (@(posedge clk) disable iff (rst)
    q_drive |-> !out_en_n);

  a_r2_proc_start_reads: assert property (@(posedge clk) disable iff (rst)
    (!proc_start_n && !enable_n) |=> (q_drive == !out_en_n));

  a_r3_ctrl_write_releases: assert property (@(posedge clk) disable iff (rst)
    (proc_start_n && !ctrl_start_n && !enable_n && !(&wr_lane_n)) |=> !q_drive);

  a_r4_deselect: assert property (@(posedge clk) disable iff (rst)
    (enable_n && (!proc_start_n || !ctrl_start_n)) |=> (!sel_q && !q_drive));

  a_r11_idle_stays_idle: assert property (@(posedge clk) disable iff (rst)
    (!sel_q && proc_start_n && ctrl_start_n) |=> (!sel_q && !q_drive));

  a_r6_wait_holds: assert property (@(posedge clk) disable iff (rst)
    (sel_q && proc_start_n && ctrl_start_n && advance_n) |=> $stable(lo_q));

  a_r7_step_mod4: assert property (@(posedge clk) disable iff (rst)
    (sel_q && proc_start_n && ctrl_start_n && !advance_n) |=> (lo_q == $past(lo_q) + 2'd1));
endmodule

bind burst_sram burst_sram_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .proc_start_n(proc_start_n), .ctrl_start_n(ctrl_start_n),
  .advance_n(advance_n), .enable_n(enable_n), .wr_lane_n(wr_lane_n),
  .out_en_n(out_en_n), .q_drive(q_drive), .sel_q(sel_q), .lo_q(lo_q)
);

// File: tb/burst_sram_test.sv
module burst_sram_test;
  localparam int AW = 8;
  localparam int DW = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic ps_n = 1'b1, cs_n = 1'b1, adv_n = 1'b1, en_n = 1'b1, oe_n = 1'b0;
  logic [1:0] wl_n = 2'b11;
  logic [DW-1:0] wd = '0;
  logic [DW-1:0] q;
  logic q_drive;

  burst_sram #(.ADDR_W(AW), .LANE_W(9), .LANES(2)) uut (
    .clk(clk), .rst(rst), .addr(addr), .proc_start_n(ps_n), .ctrl_start_n(cs_n),
    .advance_n(adv_n), .enable_n(en_n), .wr_lane_n(wl_n), .out_en_n(oe_n),
    .wdata(wd), .q(q), .q_drive(q_drive)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  string req = "R1";

  logic [DW-1:0] mm [0:(1<<AW)-1];
  bit m_sel = 0, m_rd = 0;
  int m_base = 0, m_off = 0;

  function automatic logic [DW-1:0] pat(int i);
    return DW'(i * 37 + 5) ^ 18'h2A5A5;
  endfunction

  task automatic check(string r, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic compare_model();
    bit exp_drv;
    exp_drv = m_sel && m_rd && !oe_n;
    check(req, DW'(q_drive), DW'(exp_drv));
    if (exp_drv) check(req, q, mm[m_base + m_off]);
  endtask

  task automatic model_edge(bit p, bit c, bit a, bit e, logic [1:0] w, int ad, logic [DW-1:0] d);
    bit wr;
    wr = 0;
    if (!p || !c) begin
      if (e) begin m_sel = 0; m_rd = 0; end
      else begin
        m_sel = 1; m_base = ad & ~3; m_off = ad & 3;
        wr = p && (w != 2'b11);
        m_rd = !wr;
      end
    end else if (m_sel) begin
      if (!a) m_off = (m_off + 1) % 4;
      wr = (w != 2'b11);
      m_rd = !wr;
    end else m_rd = 0;
    if (wr) begin
      if (!w[0]) mm[m_base + m_off][8:0]  = d[8:0];
      if (!w[1]) mm[m_base + m_off][17:9] = d[17:9];
    end
  endtask

  task automatic cyc(bit p, bit c, bit a, bit e, logic [1:0] w, int ad, logic [DW-1:0] d);
    @(negedge clk);
    compare_model();
    ps_n = p; cs_n = c; adv_n = a; en_n = e; wl_n = w; addr = AW'(ad); wd = d;
    @(posedge clk);
    model_edge(p, c, a, e, w, ad, d);
    #2;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
    check("R1", DW'(q_drive), '0);

    req = "R3";
    for (int b = 0; b < 64; b++) begin
      cyc(1, 0, 1, 0, 2'b00, b*4, pat(b*4));
      for (int k = 1; k < 4; k++) cyc(1, 1, 0, 1, 2'b00, 0, pat(b*4 + k));
    end

    req = "R7";
    for (int s = 0; s < 4; s++) begin
      int base;
      base = 32 + 16*s;
      cyc(0, 1, 1, 0, 2'b11, base + s, '0);
      check("R7", q, pat(base + s));
      for (int k = 1; k <= 4; k++) begin
        cyc(1, 1, 0, 0, 2'b11, 0, '0);
        check("R7", q, pat(base + ((s + k) % 4)));
      end
    end

    req = "R6";
    cyc(0, 1, 1, 0, 2'b11, 8'h40, '0);
    cyc(1, 1, 1, 0, 2'b11, 0, '0);
    check("R6", q, pat(8'h40));
    cyc(1, 1, 1, 0, 2'b11, 0, '0);
    check("R6", q, pat(8'h40));
    cyc(1, 1, 0, 0, 2'b11, 0, '0);
    check("R6", q, pat(8'h41));

    req = "R2";
    cyc(0, 0, 1, 0, 2'b00, 8'h50, 18'h15555);
    check("R2", q, pat(8'h50));
    cyc(0, 1, 1, 0, 2'b11, 8'h50, '0);
    check("R2", q, pat(8'h50));

    req = "R8";
    cyc(0, 1, 1, 0, 2'b11, 8'h60, '0);
    cyc(1, 1, 1, 0, 2'b00, 0, 18'h0BEEF);
    check("R8", DW'(q_drive), '0);
    cyc(0, 1, 1, 0, 2'b11, 8'h60, '0);
    check("R8", q, 18'h0BEEF);

    req = "R9";
    cyc(1, 0, 1, 0, 2'b10, 8'h70, 18'h3FFFF);
    cyc(1, 0, 1, 0, 2'b01, 8'h71, 18'h00000);
    cyc(0, 1, 1, 0, 2'b11, 8'h70, '0);
    check("R9", q, {pat(8'h70)[17:9], 9'h1FF});
    cyc(0, 1, 1, 0, 2'b11, 8'h71, '0);
    check("R9", q, {9'h000, pat(8'h71)[8:0]});

    req = "R3";
    cyc(1, 0, 1, 0, 2'b11, 8'h74, '0);
    check("R3", q, pat(8'h74));

    req = "R4";
    cyc(1, 0, 1, 1, 2'b00, 8'h80, 18'h12345);
    check("R4", DW'(q_drive), '0);
    req = "R11";
    cyc(1, 1, 0, 0, 2'b00, 0, 18'h2AAAA);
    cyc(1, 1, 1, 1, 2'b00, 0, 18'h2AAAA);
    check("R11", DW'(q_drive), '0);
    cyc(0, 1, 1, 0, 2'b11, 8'h80, '0);
    check("R4", q, pat(8'h80));
    cyc(0, 1, 1, 0, 2'b11, 8'h81, '0);
    check("R11", q, pat(8'h81));
    cyc(0, 1, 1, 0, 2'b11, 8'h76, '0);
    check("R11", q, pat(8'h76));

    req = "R5";
    cyc(0, 1, 1, 0, 2'b11, 8'h90, '0);
    cyc(1, 1, 0, 1, 2'b11, 0, '0);
    check("R5", q, pat(8'h91));
    check("R5", DW'(q_drive), 18'd1);

    req = "R10";
    oe_n = 1'b1; #1;
    check("R10", DW'(q_drive), '0);
    check("R10", q, '0);
    oe_n = 1'b0; #1;
    check("R10", DW'(q_drive), 18'd1);
    cyc(1, 1, 1, 0, 2'b11, 0, '0);

    @(negedge clk);
    compare_model();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule